// File: doc/BRIEF.md
# Two-Group Lookahead Adder/Subtractor

This block adds or subtracts two 8-bit operands in one pass of static combinational logic. The same datapath serves unsigned and twos-complement arithmetic. It has no clock and no storage, and each output follows its inputs within the same cycle.

The width is split into two identical 4-bit lookahead groups. Inside a group, each bit forms a propagate term (the XOR of its operand bits) and a generate term (their AND). Every carry in the group is then built straight from those terms and the group's carry-in, and no carry ripples from bit to bit. Each sum bit is the bit's propagate term XORed with the carry into that bit. The carry-out of the low group feeds the carry-in of the high group.

To subtract, the B operand is inverted bit by bit and the carry-in of the low group is forced to 1. The block reports the 8-bit result, the carry-out of the top bit, and a signed overflow flag. In subtract mode the carry-out means "no borrow".

Top module: `la_addsub`

## Requirements
- R1: With sub_i = 0, res_o equals (opa_i + opb_i) modulo 256.
- R2: With sub_i = 0, cout_o is 1 exactly when the unsigned sum opa_i + opb_i exceeds 255.
- R3: With sub_i = 1, res_o equals (opa_i - opb_i) modulo 256.
- R4: With sub_i = 1, cout_o is 1 exactly when opa_i is greater than or equal to opb_i, both read as unsigned (1 = no borrow).
- R5: In both modes, ovf_o is 1 exactly when the twos-complement result of opa_i plus opb_i (sub_i = 0) or opa_i minus opb_i (sub_i = 1) lies outside -128 to 127.
- R6: With sub_i = 1 and opa_i equal to opb_i, res_o is 0 and cout_o is 1.
- R7: A carry out of bit 3 reaches bit 4 through the link between the groups, so 0x0F + 0x01 gives 0x10 and 0xFF + 0x01 gives 0x00 with cout_o = 1.
- R8: With sub_i = 0 and opb_i = 0, res_o equals opa_i and both cout_o and ovf_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 8 | First operand (minuend when subtracting) |
| opb_i | input | 8 | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | Operation select: 0 = add, 1 = subtract |
| res_o | output | 8 | Sum or difference, modulo 256 |
| cout_o | output | 1 | Carry out of bit 7; in subtract mode, 1 means no borrow |
| ovf_o | output | 1 | Signed overflow |

## Verification
There is no register between any input and any output, so res_o, cout_o and ovf_o are all due in the same cycle as the operands that produce them, with zero cycles of latency. The driver applies a new operand set on each rising edge and queues the expected result. The monitor pops that item at the following falling edge, half a period later, when the combinational outputs have settled and before the next set is applied. Each popped item is therefore compared only against the operands that produced it.

// File: rtl/la_addsub_pkg.sv
package la_addsub_pkg;

    // Operation select carried on sub_i
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } la_op_e;

    // Default lookahead group width; wider groups grow the carry terms quadratically
    localparam int unsigned LA_GROUP_W_DEF = 4;
    localparam int unsigned LA_DATA_W_DEF  = 8;

endpackage

// File: rtl/la_operand_cond.sv
module la_operand_cond #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] opb_i,
    input  logic         sub_i,
    output logic [W-1:0] opb_eff_o,
    output logic         cin_o
);
    import la_addsub_pkg::*;

    la_op_e op;

    always_comb begin
        op        = la_op_e'(sub_i);
        opb_eff_o = (op == OP_SUB) ? ~opb_i : opb_i;
        cin_o     = (op == OP_SUB);
    end

endmodule

// File: rtl/la_pg_gen.sv
module la_pg_gen #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prop_o,
    output logic [W-1:0] gen_o
);

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign prop_o[k] = a_i[k] ^ b_i[k];
        assign gen_o[k]  = a_i[k] & b_i[k];
    end

endmodule

// File: rtl/la_carry_gen.sv
module la_carry_gen #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] gen_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o
);

    // Each carry is a flat OR of product terms over prop/gen and cin,
    // so no carry depends on a lower carry of the same group.
    always_comb begin
        carry_o[0] = cin_i;
        for (int i = 0; i < W; i++) begin
            logic acc;
            logic term;
            acc = gen_i[i];
            for (int j = 0; j < i; j++) begin
                term = gen_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    term = term & prop_i[k];
                end
                acc = acc | term;
            end
            term = cin_i;
            for (int k = 0; k <= i; k++) begin
                term = term & prop_i[k];
            end
            carry_o[i+1] = acc | term;
        end
    end

endmodule

// File: rtl/la_sum_gen.sv
module la_sum_gen #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_in_i,
    output logic [W-1:0] sum_o
);

    for (genvar k = 0; k < W; k++) begin : g_bit
        assign sum_o[k] = prop_i[k] ^ carry_in_i[k];
    end

endmodule

// File: rtl/la_group.sv
module la_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic [W:0]   carry_o
);

    logic [W-1:0] prop;
    logic [W-1:0] gen;

    la_pg_gen #(.W(W)) i_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .prop_o (prop),
        .gen_o  (gen)
    );

    la_carry_gen #(.W(W)) i_carry (
        .prop_i  (prop),
        .gen_i   (gen),
        .cin_i   (cin_i),
        .carry_o (carry_o)
    );

    la_sum_gen #(.W(W)) i_sum (
        .prop_i     (prop),
        .carry_in_i (carry_o[W-1:0]),
        .sum_o      (sum_o)
    );

endmodule

// File: rtl/la_addsub.sv
module la_addsub #(
    parameter int unsigned DATA_W  = la_addsub_pkg::LA_DATA_W_DEF,
    parameter int unsigned GROUP_W = la_addsub_pkg::LA_GROUP_W_DEF
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              ovf_o
);

    localparam int unsigned NUM_GROUPS = DATA_W / GROUP_W;
    localparam int unsigned MSB        = DATA_W - 1;

    logic [DATA_W-1:0] opb_eff;
    logic              cin0;
    // carry into every bit position, plus the final carry-out
    logic [DATA_W:0]   carry_all;

    la_operand_cond #(.W(DATA_W)) i_cond (
        .opb_i     (opb_i),
        .sub_i     (sub_i),
        .opb_eff_o (opb_eff),
        .cin_o     (cin0)
    );

    assign carry_all[0] = cin0;

    // Groups chained: group n's carry-out is group n+1's carry-in
    for (genvar n = 0; n < NUM_GROUPS; n++) begin : g_grp
        logic [GROUP_W:0] grp_carry;

        la_group #(.W(GROUP_W)) i_grp (
            .a_i     (opa_i[n*GROUP_W +: GROUP_W]),
            .b_i     (opb_eff[n*GROUP_W +: GROUP_W]),
            .cin_i   (carry_all[n*GROUP_W]),
            .sum_o   (res_o[n*GROUP_W +: GROUP_W]),
            .carry_o (grp_carry)
        );

        assign carry_all[n*GROUP_W+1 +: GROUP_W] = grp_carry[GROUP_W:1];
    end

    assign cout_o = carry_all[DATA_W];
    assign ovf_o  = carry_all[MSB] ^ carry_all[DATA_W];

endmodule

// File: rtl/la_addsub_chk.sv
module la_addsub_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic [DATA_W-1:0] opa_i,
    input logic [DATA_W-1:0] opb_i,
    input logic              sub_i,
    input logic [DATA_W-1:0] res_o,
    input logic              cout_o,
    input logic              ovf_o
);

    localparam int unsigned MSB = DATA_W - 1;

    always_comb begin
        if (!$isunknown({opa_i, opb_i, sub_i, res_o, cout_o, ovf_o})) begin
            // R8
            if (!sub_i && opb_i == '0) begin
                zero_b_add_chk: assert (res_o == opa_i && !cout_o && !ovf_o);
            end
            // R6
            if (sub_i && opa_i == opb_i) begin
                equal_sub_chk: assert (res_o == '0 && cout_o);
            end
            // R5
            if (ovf_o) begin
                ovf_sign_chk: assert (opa_i[MSB] == (opb_i[MSB] ^ sub_i) && res_o[MSB] != opa_i[MSB]);
            end
            // R4
            if (sub_i) begin
                no_borrow_chk: assert (cout_o == (opa_i >= opb_i));
            end
            // R2
            if (!sub_i) begin
                add_carry_chk: assert (cout_o == (opa_i > ~opb_i));
            end
        end
    end

endmodule

bind la_addsub la_addsub_chk #(.DATA_W(DATA_W)) i_la_addsub_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .sub_i  (sub_i),
    .res_o  (res_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/test_la_addsub.sv
module test_la_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 190000;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic       sub;
        logic [7:0] res;
        logic       cout;
        logic       ovf;
        string      rtag;
        string      ctag;
        string      otag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = 8'h00;
    logic [7:0] opb = 8'h00;
    logic       sub_m = 1'b0;
    logic [7:0] res;
    logic       cout;
    logic       ovf;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    la_addsub i_la_addsub (
        .opa_i  (opa),
        .opb_i  (opb),
        .sub_i  (sub_m),
        .res_o  (res),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    task automatic report_end();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    // Driver: apply operands at a rising edge, queue the expected result
    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic sub, input string tag);
        item_t it;
        int    sa;
        int    sb;
        int    sr;
        int    ua;
        int    ub;
        @(posedge clk);
        opa   = a;
        opb   = b;
        sub_m = sub;
        ua = int'(a);
        ub = int'(b);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        it.a = a;
        it.b = b;
        it.sub = sub;
        if (sub) begin
            it.res  = 8'((ua - ub + 256) % 256);
            it.cout = (ua >= ub);
            sr      = sa - sb;
            it.rtag = "R3";
            it.ctag = "R4";
        end else begin
            it.res  = 8'((ua + ub) % 256);
            it.cout = (ua + ub) > 255;
            sr      = sa + sb;
            it.rtag = "R1";
            it.ctag = "R2";
        end
        it.ovf  = (sr > 127) || (sr < -128);
        it.otag = "R5";
        if (tag != "") begin
            it.rtag = tag;
            it.ctag = tag;
            it.otag = tag;
        end
        sbq.push_back(it);
    endtask

    // Monitor: outputs are due in the same cycle; sample half a period later
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                n_checks++;
                if (res !== it.res) begin
                    n_errors++;
                    $display("FAIL %s res a=%h b=%h sub=%b actual=%h expected=%h",
                             it.rtag, it.a, it.b, it.sub, res, it.res);
                end
                n_checks++;
                if (cout !== it.cout) begin
                    n_errors++;
                    $display("FAIL %s cout a=%h b=%h sub=%b actual=%b expected=%b",
                             it.ctag, it.a, it.b, it.sub, cout, it.cout);
                end
                n_checks++;
                if (ovf !== it.ovf) begin
                    n_errors++;
                    $display("FAIL %s ovf a=%h b=%h sub=%b actual=%b expected=%b",
                             it.otag, it.a, it.b, it.sub, ovf, it.ovf);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired after %0d cycles", WDOG_LIMIT);
        report_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Initial state: zero operands, add mode (R8)
        drive(8'h00, 8'h00, 1'b0, "R8");
        drive(8'h5A, 8'h00, 1'b0, "R8");
        drive(8'h80, 8'h00, 1'b0, "R8");

        // Equal operands in subtract mode (R6)
        drive(8'h37, 8'h37, 1'b1, "R6");
        drive(8'h00, 8'h00, 1'b1, "R6");
        drive(8'hFF, 8'hFF, 1'b1, "R6");

        // Carry crossing the group boundary (R7)
        drive(8'h0F, 8'h01, 1'b0, "R7");
        drive(8'hFF, 8'h01, 1'b0, "R7");
        drive(8'h08, 8'h08, 1'b0, "R7");
        drive(8'h10, 8'h01, 1'b1, "R7");

        // Signed overflow corners (R5)
        drive(8'h7F, 8'h01, 1'b0, "R5");
        drive(8'h80, 8'hFF, 1'b0, "R5");
        drive(8'h80, 8'h01, 1'b1, "R5");
        drive(8'h7F, 8'hFF, 1'b1, "R5");

        // Exhaustive sweep in both modes (R1, R2, R3, R4, R5)
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    drive(8'(a), 8'(b), m[0], "");
                end
            end
        end

        @(negedge clk);
        @(negedge clk);
        report_end();
    end

endmodule